// File: doc/BRIEF.md
# Timer Output Compare Unit

This block pairs a free-running period timer with a compare stage that drives one output pin. Software programs a control word holding a mode code and an enable bit, a primary compare value, a secondary compare value and the timer period. In every clock cycle the timer count is compared with both compare values. When the active mode calls for it, a match moves the pin to a new level on the following clock edge.

Two single-edge modes force the pin high or low when the count reaches the primary value. A dual-edge mode produces a repeating pulse once per timer period. An event flag records every match that actually changes the pin. Software clears the flag by writing a one to a dedicated address. The mode can be rewritten while the unit runs, so a waveform made of separate edges can be built one edge at a time, and each edge lands exactly on a timer match.

Top module: `timerCompareUnit`

## Requirements
- R1: While reset is asserted and right after it, the pin is low, the event flag is clear, the timer reads 0 and the unit is disabled.
- R2: The timer counts up by one every clock. It returns to 0 on the clock after the cycle in which it is at or above the period register.
- R3: Writes use address 0 for control (mode in bits [2:0], enable in bit 15), address 1 for the primary value, address 2 for the secondary value, address 3 for the period, and address 4 for flag clear (bit 0). A written value governs from the cycle after the write edge.
- R4: In mode 001 with the unit enabled, the pin goes high on the clock edge that ends a cycle in which the timer equals the primary value.
- R5: In mode 010 with the unit enabled, the pin goes low in the same way. A primary value of 0 puts that edge at the start of a timer period.
- R6: In mode 101 with the unit enabled, a primary match drives the pin high and a secondary match drives it low. Per period the pin is high for (secondary − primary) mod (period + 1) cycles, so swapping the two values inverts the pulse.
- R7: In mode 101, when primary equals secondary, the secondary match wins and the pin is driven low.
- R8: While the unit is disabled, or enabled with a mode code other than 001, 010 or 101, the pin holds its level and the event flag is not set.
- R9: The event flag sets on every match that changes the pin level and on no other match. It stays set until a flag-clear write. A set in the same cycle as a clear wins.
- R10: Rewriting the control word does not change the current pin level. The new mode acts first at the next qualifying match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| cmpOut | output | 1 | Compare output pin |
| eventFlag | output | 1 | Sticky output-change event flag |
| timerValue | output | 16 | Current timer count |

## Verification
Two situations are hardest to reach from the ports. The first is a flag clear that meets an output-changing match in the same cycle. The bench reaches it by polling the timer on falling edges until it shows the primary value, then issuing the clear write, so that the write edge coincides with the match edge. The second is a mode rewrite while the pin is already high. The bench first sets the pin with the single-high mode, then writes the single-low mode mid-period. It then checks that the level survives the write and falls exactly one edge after the timer shows the primary value.

// File: rtl/timerComparePkg.sv
package timerComparePkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRI    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEC    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd4;

  localparam int ENABLE_BIT = 15;
  localparam int MODE_W     = 3;

  localparam logic [MODE_W-1:0] MODE_SET_HIGH = 3'b001;
  localparam logic [MODE_W-1:0] MODE_SET_LOW  = 3'b010;
  localparam logic [MODE_W-1:0] MODE_PULSE    = 3'b101;

  typedef struct packed {
    logic driveHigh;
    logic driveLow;
    logic clrFlag;
  } cmpStrobe_t;
endpackage

// File: rtl/timerCompareCtrl.sv
module timerCompareCtrl
  import timerComparePkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] PERIOD_INIT = CNT_W'(999)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                priMatch,
  input  logic                secMatch,
  output logic [CNT_W-1:0]    priCmp,
  output logic [CNT_W-1:0]    secCmp,
  output logic [CNT_W-1:0]    periodVal,
  output logic [MODE_W-1:0]   ctrlMode,
  output logic                ctrlEn,
  output cmpStrobe_t          strobe
);
  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlMode  <= '0;
      ctrlEn    <= 1'b0;
      priCmp    <= '0;
      secCmp    <= '0;
      periodVal <= PERIOD_INIT;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          ctrlMode <= wrData[MODE_W-1:0];
          ctrlEn   <= wrData[ENABLE_BIT];
        end
        ADDR_PRI:    priCmp    <= wrData[CNT_W-1:0];
        ADDR_SEC:    secCmp    <= wrData[CNT_W-1:0];
        ADDR_PERIOD: periodVal <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // mode decode into strobes for the datapath
  always_comb begin
    strobe = '0;
    strobe.clrFlag = wrEn && (wrAddr == ADDR_FLAG) && wrData[0];
    if (ctrlEn) begin
      case (ctrlMode)
        MODE_SET_HIGH: strobe.driveHigh = priMatch;
        MODE_SET_LOW:  strobe.driveLow  = priMatch;
        MODE_PULSE: begin
          strobe.driveLow  = secMatch;
          strobe.driveHigh = priMatch && !secMatch;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/timerCompareDatapath.sv
module timerCompareDatapath
  import timerComparePkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] priCmp,
  input  logic [CNT_W-1:0] secCmp,
  input  logic [CNT_W-1:0] periodVal,
  input  cmpStrobe_t       strobe,
  output logic             priMatch,
  output logic             secMatch,
  output logic [CNT_W-1:0] timerQ,
  output logic             outQ,
  output logic             flagQ
);
  logic nextOut;
  logic levelChange;

  // period timer, wraps at or above the period value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   timerQ <= '0;
    else if (timerQ >= periodVal) timerQ <= '0;
    else                          timerQ <= timerQ + CNT_W'(1);
  end

  assign priMatch = (timerQ == priCmp);
  assign secMatch = (timerQ == secCmp);

  always_comb begin
    if (strobe.driveHigh)     nextOut = 1'b1;
    else if (strobe.driveLow) nextOut = 1'b0;
    else                      nextOut = outQ;
  end

  assign levelChange = (nextOut != outQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      outQ <= nextOut;
      if (levelChange)         flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/timerCompareUnit.sv
module timerCompareUnit
  import timerComparePkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] PERIOD_INIT = CNT_W'(999)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [15:0]       wrData,
  output logic              cmpOut,
  output logic              eventFlag,
  output logic [15:0]       timerValue
);
  logic [CNT_W-1:0]  priCmp;
  logic [CNT_W-1:0]  secCmp;
  logic [CNT_W-1:0]  periodVal;
  logic [MODE_W-1:0] ctrlMode;
  logic              ctrlEn;
  logic              priMatch;
  logic              secMatch;
  logic [CNT_W-1:0]  timerQ;
  cmpStrobe_t        strobe;

  timerCompareCtrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PERIOD_INIT(PERIOD_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .priMatch(priMatch), .secMatch(secMatch),
    .priCmp(priCmp), .secCmp(secCmp), .periodVal(periodVal),
    .ctrlMode(ctrlMode), .ctrlEn(ctrlEn), .strobe(strobe)
  );

  timerCompareDatapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .priCmp(priCmp), .secCmp(secCmp),
    .periodVal(periodVal), .strobe(strobe),
    .priMatch(priMatch), .secMatch(secMatch),
    .timerQ(timerQ), .outQ(cmpOut), .flagQ(eventFlag)
  );

  assign timerValue = timerQ;
endmodule

// File: rtl/timerCompareChecker.sv
module timerCompareChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       ctrlMode,
  input logic             ctrlEn,
  input logic [CNT_W-1:0] priCmp,
  input logic [CNT_W-1:0] secCmp,
  input logic [15:0]      timerValue,
  input logic             cmpOut,
  input logic             eventFlag
);
  // R2: the timer either steps by one or returns to zero
  a_r2_timer_step: assert property (@(posedge clk) disable iff (!rstN)
    (timerValue == '0) || (timerValue == $past(timerValue) + 16'd1));

  // R4: single-high mode sets the pin one edge after a primary match
  a_r4_set_high: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlEn) && $past(ctrlMode) == 3'b001 && $past(timerValue) == $past(priCmp))
    |-> cmpOut);

  // R5: single-low mode clears the pin one edge after a primary match
  a_r5_set_low: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlEn) && $past(ctrlMode) == 3'b010 && $past(timerValue) == $past(priCmp))
    |-> !cmpOut);

  // R6: dual mode rises on a primary match with distinct values
  a_r6_pulse_rise: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlEn) && $past(ctrlMode) == 3'b101 && $past(timerValue) == $past(priCmp)
     && $past(priCmp) != $past(secCmp)) |-> cmpOut);

  // R7: dual mode falls on any secondary match, including equal values
  a_r7_pulse_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlEn) && $past(ctrlMode) == 3'b101 && $past(timerValue) == $past(secCmp))
    |-> !cmpOut);

  // R8: a disabled unit keeps the pin level
  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlEn) |-> $stable(cmpOut));

  // R9: the flag rises only together with a pin change
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventFlag) |-> (cmpOut != $past(cmpOut)));
endmodule

bind timerCompareUnit timerCompareChecker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .ctrlEn(ctrlEn),
  .priCmp(priCmp), .secCmp(secCmp), .timerValue(timerValue),
  .cmpOut(cmpOut), .eventFlag(eventFlag)
);

// File: tb/timerCompareUnit_bench.sv
`timescale 1ns/1ps
module timerCompareUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        cmpOut;
  logic        eventFlag;
  logic [15:0] timerValue;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  localparam int PERIOD = 19;
  localparam int NVEC = 7;
  // dual-mode vectors: primary, secondary, expected high cycles per period
  localparam logic [15:0] VEC_PRI [NVEC] = '{16'd2,  16'd10, 16'd0,  16'd19, 16'd5, 16'd7, 16'd0};
  localparam logic [15:0] VEC_SEC [NVEC] = '{16'd10, 16'd2,  16'd19, 16'd0,  16'd6, 16'd7, 16'd0};
  localparam int          VEC_EXP [NVEC] = '{8,      12,     19,     1,      1,     0,     0};

  always #2.5 clk = ~clk;

  timerCompareUnit u_timerCompareUnit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmpOut(cmpOut), .eventFlag(eventFlag), .timerValue(timerValue)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTimer(input int v);
    while (int'(timerValue) != v) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int highs;
    int prev;
    repeat (3) @(negedge clk);
    check("R1 pin", int'(cmpOut), 0);
    check("R1 flag", int'(eventFlag), 0);
    check("R1 timer", int'(timerValue), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pin after release", int'(cmpOut), 0);

    // period register and wrap
    wrReg(3'd3, 16'(PERIOD));
    waitTimer(PERIOD);
    @(negedge clk);
    check("R3 period write gives R2 wrap", int'(timerValue), 0);
    prev = int'(timerValue);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      check("R2 count sequence", int'(timerValue), (prev == PERIOD) ? 0 : prev + 1);
      prev = int'(timerValue);
    end

    // dual-mode vector table
    for (int i = 0; i < NVEC; i++) begin
      wrReg(3'd0, 16'h0000);
      wrReg(3'd1, VEC_PRI[i]);
      wrReg(3'd2, VEC_SEC[i]);
      wrReg(3'd0, 16'h8005);
      waitTimer(0); @(negedge clk); waitTimer(0);
      highs = 0;
      for (int c = 0; c <= PERIOD; c++) begin
        highs += int'(cmpOut);
        @(negedge clk);
      end
      if (VEC_PRI[i] == VEC_SEC[i]) check("R7 equal values keep pin low", highs, VEC_EXP[i]);
      else                           check("R6 pulse width", highs, VEC_EXP[i]);
    end

    // single-high mode with primary 7
    wrReg(3'd0, 16'h0000);
    wrReg(3'd4, 16'h0001);
    check("R9 clear write", int'(eventFlag), 0);
    wrReg(3'd1, 16'd7);
    wrReg(3'd0, 16'h8001);
    waitTimer(7);
    check("R4 pin before match edge", int'(cmpOut), 0);
    @(negedge clk);
    check("R4 pin high after match", int'(cmpOut), 1);
    check("R9 flag on change", int'(eventFlag), 1);

    wrReg(3'd4, 16'h0001);
    check("R9 flag cleared", int'(eventFlag), 0);
    repeat (PERIOD + 3) @(negedge clk);
    check("R9 no flag without level change", int'(eventFlag), 0);

    // rewrite mode while running
    wrReg(3'd0, 16'h8002);
    check("R10 level kept across write", int'(cmpOut), 1);
    waitTimer(7);
    check("R10 level until match", int'(cmpOut), 1);
    @(negedge clk);
    check("R10 falls at next match", int'(cmpOut), 0);
    check("R10 flag on fall", int'(eventFlag), 1);

    // primary zero: edge at period start
    wrReg(3'd1, 16'd0);
    wrReg(3'd0, 16'h8001);
    waitTimer(0); @(negedge clk);
    check("R4 high with primary 0", int'(cmpOut), 1);
    wrReg(3'd0, 16'h8002);
    waitTimer(0);
    check("R5 high before period start", int'(cmpOut), 1);
    @(negedge clk);
    check("R5 low at period start", int'(cmpOut), 0);

    // disabled and undefined modes
    wrReg(3'd4, 16'h0001);
    wrReg(3'd0, 16'h0001);
    repeat (PERIOD + 3) @(negedge clk);
    check("R8 disabled keeps low", int'(cmpOut), 0);
    check("R8 disabled no flag", int'(eventFlag), 0);
    wrReg(3'd0, 16'h8001);
    waitTimer(0); @(negedge clk);
    wrReg(3'd4, 16'h0001);
    wrReg(3'd0, 16'h0002);
    repeat (PERIOD + 3) @(negedge clk);
    check("R8 disabled keeps high", int'(cmpOut), 1);
    wrReg(3'd0, 16'h8003);
    repeat (PERIOD + 3) @(negedge clk);
    check("R8 undefined mode keeps high", int'(cmpOut), 1);
    check("R8 undefined mode no flag", int'(eventFlag), 0);

    // set beats clear in the same cycle
    wrReg(3'd1, 16'd5);
    wrReg(3'd0, 16'h8002);
    waitTimer(5);
    wrReg(3'd4, 16'h0001);
    check("R9 pin fell on clear cycle", int'(cmpOut), 0);
    check("R9 set wins over clear", int'(eventFlag), 1);

    finishRun();
  end
endmodule